// File: doc/BRIEF.md
# Summed Uniform-to-Gaussian Noise Synthesizer

The block turns a set of binary pseudorandom streams into one digital noise sample per enabled clock. Every stream feeds its own short shift register. Because the register bits carry power-of-two weights, the register contents read directly as an unsigned code. That code acts as a small low-pass filter on the stream, and its values are evenly spread. The block adds the codes of all sections into one unsigned sample, which is registered for a converter outside the block. Adding many independent, evenly spread codes gives an amplitude distribution that is close to a bell curve. With twelve sections the largest swing is about six times the RMS level.

The noise bandwidth follows the shift clock, which here is the enabled clock. The amplitude statistics depend only on the number of sections and their width, not on the clock rate. A valid flag marks each sample that was taken after the registers were completely filled following reset. Reset is asynchronous and active-low, and it is expected to be released synchronously to the clock.

Top module: `noise_sum_synth`

## Requirements
- R1: On each clock with `en_i` high, section i (driven by `bits_i[i]`) shifts its register left by one place and loads the new bit at bit 0. The section code is the register value: the newest bit has weight 1 and the bit taken 7 shifts earlier has weight 128.
- R2: On the clock after an enabled shift, `sample_o` becomes the unsigned sum of all section codes as they stand after that shift.
- R3: `sample_o` is a 12-bit unsigned value and never exceeds 3060. With all streams held at 1 for 8 shifts it reads 3060, and with all streams held at 0 for 8 shifts it reads 0.
- R4: `valid_o` is high for exactly the clock after an enabled shift, and only when at least 8 enabled shifts have occurred since reset.
- R5: While `en_i` is low, the section registers keep their values, `sample_o` holds its last value and `valid_o` is low on the following clock.
- R6: While `rst_ni` is low, all section registers, `sample_o` and `valid_o` are cleared to 0 at once. After release, `valid_o` stays low until 8 new enabled shifts have occurred.
- R7: When every section is driven by the same maximal-length degree-8 sequence, the valid samples over 255 consecutive shifts are each 12 times a section code, and every nonzero code from 1 to 255 appears exactly once.
- R8: With independent, evenly distributed random streams, the long-run mean of the valid samples is close to 1530 and their variance is close to 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift and sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Shift enable for all sections |
| bits_i | input | 12 | One pseudorandom bit per section; bit i feeds section i |
| sample_o | output | 12 | Registered unsigned sum of the section codes |
| valid_o | output | 1 | Marks a fresh sample taken after the registers were filled |

## Verification
The bench builds the block with its default parameters: twelve sections of eight bits. This makes the full code range reachable, including the exact peak of 3060 and the floor of 0. It also makes the full 255-step period of a degree-8 maximal sequence short enough to walk completely, so that every nonzero section code can be shown to appear once. With the same sizes, the theoretical mean of 1530 and variance of 65535 give the statistical checks fixed targets. These targets can be reached within a run of some twenty thousand samples.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  localparam int DEF_SECTIONS = 12;
  localparam int DEF_SEC_W    = 8;

  // Width that holds the sum of n unsigned codes of w bits each.
  function automatic int sum_width(input int n, input int w);
    return w + $clog2(n);
  endfunction

  // Largest value the sum can take.
  function automatic int peak_sum(input int n, input int w);
    return n * ((1 << w) - 1);
  endfunction

endpackage

// File: rtl/nsg_section.sv
module nsg_section #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] code_o
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  // The newest bit lands at weight 1; older bits move toward the MSB.
  always_comb begin
    sr_d = sr_q;
    if (en_i) begin
      sr_d = {sr_q[W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign code_o = sr_q;

endmodule

// File: rtl/nsg_fill.sv
module nsg_fill #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic full_o
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(W));

  // Counts enabled shifts and stops once a full register's worth has arrived.
  always_comb begin
    cnt_d = cnt_q;
    if (en_i && !at_limit) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign full_o = at_limit;

endmodule

// File: rtl/nsg_adder.sv
module nsg_adder #(
  parameter int N  = 12,
  parameter int W  = 8,
  parameter int SW = 12
) (
  input  logic [N*W-1:0] codes_i,
  output logic [SW-1:0]  sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + SW'(codes_i[i*W +: W]);
    end
  end

endmodule

// File: rtl/noise_sum_synth.sv
module noise_sum_synth
  import nsg_pkg::*;
#(
  parameter  int NUM_SEC = DEF_SECTIONS,
  parameter  int SEC_W   = DEF_SEC_W,
  localparam int SUM_W   = sum_width(NUM_SEC, SEC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [NUM_SEC-1:0] bits_i,
  output logic [SUM_W-1:0]   sample_o,
  output logic               valid_o
);

  logic [NUM_SEC*SEC_W-1:0] codes;
  logic [SUM_W-1:0]         sum_c;
  logic                     filled;

  logic                     en_q;
  logic                     en_d;
  logic [SUM_W-1:0]         sample_q;
  logic [SUM_W-1:0]         sample_d;
  logic                     valid_q;
  logic                     valid_d;

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    nsg_section #(
      .W(SEC_W)
    ) u_sec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .bit_i  (bits_i[g]),
      .code_o (codes[g*SEC_W +: SEC_W])
    );
  end

  nsg_fill #(
    .W(SEC_W)
  ) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .full_o (filled)
  );

  nsg_adder #(
    .N (NUM_SEC),
    .W (SEC_W),
    .SW(SUM_W)
  ) u_add (
    .codes_i (codes),
    .sum_o   (sum_c)
  );

  // Output stage: capture the sum one clock after each enabled shift.
  always_comb begin
    en_d     = en_i;
    sample_d = sample_q;
    if (en_q) begin
      sample_d = sum_c;
    end
    valid_d  = en_q & filled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      en_q     <= en_d;
      sample_q <= sample_d;
      valid_q  <= valid_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker
  import nsg_pkg::*;
#(
  parameter int N  = 12,
  parameter int W  = 8,
  parameter int SW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [SW-1:0] sample_o,
  input logic          valid_o
);

  localparam int CW   = $clog2(W + 1);
  localparam int PEAK = peak_sum(N, W);

  // Independent count of enabled shifts since reset, saturating at W.
  logic [CW-1:0] chk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt <= '0;
    end else if (en_i && chk_cnt != CW'(W)) begin
      chk_cnt <= chk_cnt + CW'(1);
    end
  end

  // R3: the sample never leaves the reachable range.
  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sample_o) <= PEAK);

  // R4: a valid sample follows an enabled shift (shift, capture, then visible).
  p_valid_after_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i, 2));

  // R4: no valid sample before the registers have been filled.
  p_valid_needs_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (chk_cnt == CW'(W)));

  // R5: without a shift, the sample holds and no valid pulse appears.
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i, 2) |-> ($stable(sample_o) && !valid_o));

  // R6: reset clears the outputs.
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r6: assert (sample_o == '0 && !valid_o);
    end
  end

endmodule

bind noise_sum_synth nsg_checker #(
  .N (NUM_SEC),
  .W (SEC_W),
  .SW(SUM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sample_o (sample_o),
  .valid_o  (valid_o)
);

// File: tb/noise_sum_synth_tb_top.sv
`timescale 1ns/1ps
module noise_sum_synth_tb_top;

  localparam int NS = 12;
  localparam int SWD = 8;
  localparam int OW = 12;
  localparam int NT = 12;

  // Vector fields: [25] enable, [24:13] stream bits, [12:1] expected sample, [0] expected valid
  localparam logic [25:0] TBL [NT] = '{
    {1'b1, 12'hFFF, 12'd12,   1'b0},
    {1'b1, 12'hFFF, 12'd36,   1'b0},
    {1'b1, 12'hFFF, 12'd84,   1'b0},
    {1'b1, 12'hFFF, 12'd180,  1'b0},
    {1'b1, 12'hFFF, 12'd372,  1'b0},
    {1'b1, 12'hFFF, 12'd756,  1'b0},
    {1'b1, 12'hFFF, 12'd1524, 1'b0},
    {1'b1, 12'hFFF, 12'd3060, 1'b1},
    {1'b0, 12'hFFF, 12'd3060, 1'b0},
    {1'b1, 12'h000, 12'd3048, 1'b1},
    {1'b1, 12'h001, 12'd3025, 1'b1},
    {1'b1, 12'h800, 12'd2979, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [NS-1:0] bits;
  logic [OW-1:0] sample;
  logic          valid;

  always #2.5 clk = ~clk;

  noise_sum_synth dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .bits_i   (bits),
    .sample_o (sample),
    .valid_o  (valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  logic [SWD-1:0] m_sr [NS];
  logic           m_enq;
  logic [OW-1:0]  m_sample;
  logic           m_valid;
  int             m_cnt;

  function automatic int m_sum();
    int s = 0;
    for (int i = 0; i < NS; i++) s += int'(m_sr[i]);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_sr[i] <= '0;
      m_enq <= 1'b0; m_sample <= '0; m_valid <= 1'b0; m_cnt <= 0;
    end else begin
      if (m_enq) m_sample <= OW'(m_sum());
      m_valid <= m_enq && (m_cnt == SWD);
      m_enq   <= en;
      if (en) begin
        for (int i = 0; i < NS; i++) m_sr[i] <= {m_sr[i][SWD-2:0], bits[i]};
        if (m_cnt < SWD) m_cnt <= m_cnt + 1;
      end
    end
  end

  // Compare against the model every cycle (R2 sample, R4 valid).
  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      chk(sample == m_sample, "R2 per-cycle sample", int'(sample), int'(m_sample));
      chk(valid == m_valid, "R4 per-cycle valid", int'(valid), int'(m_valid));
    end
  end

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  logic [25:0] ev;
  logic [7:0]  lfsr;
  logic        nb;
  bit          seen;
  int          got, bad, miss;
  int          hist [256];
  real         s1, s2, mean, vr;
  int          ns_cnt;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b1; en = 1'b0; bits = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample == 0, "R6 reset sample", int'(sample), 0);
    chk(valid == 0, "R6 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // Table walk: results appear two negedges after the vector is driven.
    for (int i = 0; i < NT + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        ev = TBL[i-2];
        chk(sample == ev[12:1], "R2 table sample", int'(sample), int'(ev[12:1]));
        chk(valid == ev[0], "R4 table valid", int'(valid), int'(ev[0]));
        if (i - 2 == 7) chk(sample == 12'd3060, "R3 peak", int'(sample), 3060);
        if (i - 2 == 8) chk(sample == 12'd3060 && !valid, "R5 hold", int'(sample), 3060);
        if (i - 2 >= 10) chk(sample == ev[12:1], "R1 section routing", int'(sample), int'(ev[12:1]));
      end
      if (i < NT) begin
        en = TBL[i][25]; bits = TBL[i][24:13];
      end else begin
        en = 1'b0;
      end
    end

    // Reset in mid-run, then refill.
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rng = xs(rng); en = 1'b1; bits = rng[NS-1:0];
    end
    @(negedge clk); en = 1'b1; bits = '1; rst_n = 1'b0;
    #1;
    chk(sample == 0, "R6 async clear sample", int'(sample), 0);
    chk(valid == 0, "R6 async clear valid", int'(valid), 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1; bits = '1;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); seen |= valid; en = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); seen |= valid; en = 1'b0;
    end
    chk(!seen, "R6 no valid before refill", int'(seen), 0);
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(valid == 1'b1, "R4 valid after eighth shift", int'(valid), 1);
    chk(sample == 12'd3060, "R3 peak after refill", int'(sample), 3060);

    // All-zero streams reach the floor.
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); en = 1'b1; bits = '0;
    end
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(sample == 0, "R3 floor", int'(sample), 0);
    chk(valid == 1'b1, "R4 floor valid", int'(valid), 1);

    // Maximal-length degree-8 stream on every section.
    @(negedge clk); rst_n = 1'b0; en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    lfsr = 8'h01; got = 0; bad = 0;
    for (int c = 0; c < 256; c++) hist[c] = 0;
    for (int j = 0; j < 262; j++) begin
      @(negedge clk);
      if (valid) begin
        got++;
        if (int'(sample) % 12 != 0) bad++; else hist[int'(sample) / 12]++;
      end
      nb = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
      lfsr = {lfsr[6:0], nb};
      en = 1'b1; bits = {NS{nb}};
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      if (valid) begin
        got++;
        if (int'(sample) % 12 != 0) bad++; else hist[int'(sample) / 12]++;
      end
      en = 1'b0;
    end
    miss = (hist[0] != 0) ? 1 : 0;
    for (int c = 1; c < 256; c++) if (hist[c] != 1) miss++;
    chk(got == 255, "R7 valid samples per period", got, 255);
    chk(bad == 0, "R7 samples are 12x a code", bad, 0);
    chk(miss == 0, "R7 each nonzero code once", miss, 0);

    // Long-run statistics with random streams.
    s1 = 0.0; s2 = 0.0; ns_cnt = 0;
    for (int j = 0; j < 20000; j++) begin
      @(negedge clk);
      if (valid) begin
        ns_cnt++;
        s1 += real'(sample);
        s2 += real'(sample) * real'(sample);
      end
      rng = xs(rng); en = 1'b1; bits = rng[NS-1:0];
    end
    @(negedge clk); en = 1'b0;
    mean = s1 / real'(ns_cnt);
    vr = s2 / real'(ns_cnt) - mean * mean;
    chk(mean > 1505.0 && mean < 1555.0, "R8 mean", $rtoi(mean), 1530);
    chk(vr > 55700.0 && vr < 75400.0, "R8 variance", $rtoi(vr), 65535);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule